// File: doc/BRIEF.md
# CAN Interframe Spacing Controller

This block follows the bus between CAN frames one nominal bit at a time. Its job is to decide when this node may begin a new frame. A data or remote frame may only start once the mandatory gap after the previous frame has elapsed. The gap is three recessive bits of intermission. An error-passive node must wait a further eight recessive suspend bits after that. Error and overload frames are not held back by the gap at all.

The block is driven by a bit-tick strobe and a bus level that has already been sampled. Bus level 1 means recessive and 0 means dominant. An end-of-frame pulse from the frame engine starts each gap. During the gap, a dominant bit is classified in one of two ways:
- In the first two intermission bits, it is an overload condition.
- From the third intermission bit on, including suspend and bus idle, it is another node's start of frame. This node then becomes a receiver.

The transmit-permit output combines the pending frame kind, the transmit request and the current gap state.

Top module: `ifs_gap_ctrl`

## Requirements
- R1: After reset, `idle_o` is 1 and `intermission_o`, `suspend_o`, `sof_pulse`, `overload_o` are 0.
- R2: An `eof_ind` pulse puts the block into intermission on the next clock and restarts the bit count, from any state. When `eof_ind` and a bit tick arrive in the same cycle, `eof_ind` wins and no start-of-frame or overload pulse is produced.
- R3: Intermission lasts exactly three recessive bit ticks. If `err_passive` is 0 at the third tick, the block enters bus idle.
- R4: If `err_passive` is 1 at the third intermission tick, the block enters suspend. After eight more recessive ticks it enters bus idle.
- R5: A dominant tick during suspend or bus idle raises `sof_pulse` in that cycle. On the next clock the block is in frame state, with all three state flags at 0.
- R6: A dominant tick on the first or second intermission bit raises `overload_o` in that cycle, with no `sof_pulse`. The block then enters frame state.
- R7: A dominant tick on the third intermission bit raises `sof_pulse`, not `overload_o`.
- R8: For a pending data frame (`pend_kind`=0) or remote frame (`pend_kind`=1), `tx_permit` is 1 only under two conditions, and only with `tx_req`=1:
  - the block is in bus idle, or
  - a recessive tick completes the last bit of the required gap.
- R9: For a pending error frame (`pend_kind`=2) or overload frame (`pend_kind`=3), `tx_permit` equals `tx_req` in every state.
- R10: A cycle without a bit tick and without `eof_ind` leaves the state unchanged, whatever the bus level.
- R11: In frame state, bus activity is ignored until the next `eof_ind`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_tick | input | 1 | One-cycle strobe per nominal bit |
| bus_rx | input | 1 | Sampled bus level, 1 = recessive |
| eof_ind | input | 1 | End of previous frame, one-cycle pulse |
| err_passive | input | 1 | Node is error passive |
| pend_kind | input | 2 | Pending frame: 0 data, 1 remote, 2 error, 3 overload |
| tx_req | input | 1 | Transmit request pending |
| tx_permit | output | 1 | Node may start the pending frame |
| intermission_o | output | 1 | Intermission in progress |
| suspend_o | output | 1 | Suspend transmission in progress |
| idle_o | output | 1 | Bus idle |
| sof_pulse | output | 1 | Start of frame seen from another node |
| overload_o | output | 1 | Dominant bit in early intermission |

## Verification
The bench runs a recessive run after each end of frame and places a single dominant bit at every position from the first intermission bit to beyond bus idle, in both error states. This sweep exposes several kinds of fault:
- A design that gets the boundary between the second and third intermission bit wrong reports overload where start of frame belongs, or the reverse.
- A miscounted suspend grants or withholds the permit one bit early or late.
- Suspend applied to an error-active node shows up as a delayed idle.

Idle cycles with a dominant bus but no tick catch a design that advances without a bit tick. Restarting the gap midway through suspend catches a bit count that is not cleared.

// File: rtl/ifs_pkg.sv
package ifs_pkg;

  typedef enum logic [1:0] {
    PH_FRAME = 2'd0,
    PH_INTER = 2'd1,
    PH_SUSP  = 2'd2,
    PH_IDLE  = 2'd3
  } ifs_phase_e;

  typedef enum logic [1:0] {
    FK_DATA   = 2'd0,
    FK_REMOTE = 2'd1,
    FK_ERROR  = 2'd2,
    FK_OVLD   = 2'd3
  } frame_kind_e;

  // Data and remote frames must wait for the gap; error and overload do not.
  function automatic logic kind_needs_gap(input logic [1:0] kind);
    return (kind == FK_DATA) || (kind == FK_REMOTE);
  endfunction

  // True when the bit now being counted is the final one of a run of len bits.
  function automatic logic is_last_bit(input int cnt, input int len);
    return (cnt + 1) == len;
  endfunction

  // True while the count sits inside the early part of intermission.
  function automatic logic in_early_window(input int cnt, input int early_bits);
    return cnt < early_bits;
  endfunction

endpackage

// File: rtl/ifs_bit_counter.sv
module ifs_bit_counter #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else if (inc) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/ifs_phase_fsm.sv
module ifs_phase_fsm
  import ifs_pkg::*;
#(
  parameter int INT_BITS  = 3,
  parameter int SUSP_BITS = 8,
  parameter int CNT_W     = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_tick,
  input  logic             bus_rx,
  input  logic             eof_ind,
  input  logic             err_passive,
  input  logic [CNT_W-1:0] cnt,
  output ifs_phase_e       phase,
  output logic             cnt_clr,
  output logic             cnt_inc,
  output logic             sof_evt,
  output logic             ovl_evt,
  output logic             gap_end_evt
);
  localparam int EARLY_BITS = INT_BITS - 1;

  ifs_phase_e phase_nxt;
  logic dom_tick, rec_tick, int_last, susp_last, early;

  assign dom_tick  = bit_tick && !bus_rx;
  assign rec_tick  = bit_tick &&  bus_rx;
  assign int_last  = is_last_bit(int'(cnt), INT_BITS);
  assign susp_last = is_last_bit(int'(cnt), SUSP_BITS);
  assign early     = in_early_window(int'(cnt), EARLY_BITS);

  always_comb begin
    phase_nxt   = phase;
    cnt_clr     = 1'b0;
    cnt_inc     = 1'b0;
    sof_evt     = 1'b0;
    ovl_evt     = 1'b0;
    gap_end_evt = 1'b0;
    if (eof_ind) begin
      phase_nxt = PH_INTER;
      cnt_clr   = 1'b1;
    end else begin
      unique case (phase)
        PH_FRAME: ;
        PH_INTER: begin
          if (dom_tick) begin
            if (early) ovl_evt = 1'b1;
            else       sof_evt = 1'b1;
            phase_nxt = PH_FRAME;
            cnt_clr   = 1'b1;
          end else if (rec_tick) begin
            if (int_last) begin
              cnt_clr = 1'b1;
              if (err_passive) phase_nxt = PH_SUSP;
              else begin
                phase_nxt   = PH_IDLE;
                gap_end_evt = 1'b1;
              end
            end else begin
              cnt_inc = 1'b1;
            end
          end
        end
        PH_SUSP: begin
          if (dom_tick) begin
            sof_evt   = 1'b1;
            phase_nxt = PH_FRAME;
            cnt_clr   = 1'b1;
          end else if (rec_tick) begin
            if (susp_last) begin
              cnt_clr     = 1'b1;
              phase_nxt   = PH_IDLE;
              gap_end_evt = 1'b1;
            end else begin
              cnt_inc = 1'b1;
            end
          end
        end
        PH_IDLE: begin
          if (dom_tick) begin
            sof_evt   = 1'b1;
            phase_nxt = PH_FRAME;
          end
        end
        default: phase_nxt = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) phase <= PH_IDLE;
    else        phase <= phase_nxt;
  end
endmodule

// File: rtl/ifs_tx_gate.sv
module ifs_tx_gate
  import ifs_pkg::*;
(
  input  logic       tx_req,
  input  logic [1:0] pend_kind,
  input  logic       in_idle,
  input  logic       gap_end_evt,
  output logic       tx_permit
);
  always_comb begin
    if (!kind_needs_gap(pend_kind)) tx_permit = tx_req;
    else                            tx_permit = tx_req && (in_idle || gap_end_evt);
  end
endmodule

// File: rtl/ifs_gap_ctrl.sv
module ifs_gap_ctrl
  import ifs_pkg::*;
#(
  parameter int INT_BITS  = 3,
  parameter int SUSP_BITS = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_tick,
  input  logic       bus_rx,
  input  logic       eof_ind,
  input  logic       err_passive,
  input  logic [1:0] pend_kind,
  input  logic       tx_req,
  output logic       tx_permit,
  output logic       intermission_o,
  output logic       suspend_o,
  output logic       idle_o,
  output logic       sof_pulse,
  output logic       overload_o
);
  localparam int MAX_BITS = (INT_BITS > SUSP_BITS) ? INT_BITS : SUSP_BITS;
  localparam int CNT_W    = $clog2(MAX_BITS + 1);

  ifs_phase_e       phase;
  logic [CNT_W-1:0] bit_cnt;
  logic             cnt_clr, cnt_inc, sof_evt, ovl_evt, gap_end_evt;

  ifs_bit_counter #(.W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (cnt_clr),
    .inc   (cnt_inc),
    .cnt   (bit_cnt)
  );

  ifs_phase_fsm #(
    .INT_BITS  (INT_BITS),
    .SUSP_BITS (SUSP_BITS),
    .CNT_W     (CNT_W)
  ) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .bit_tick    (bit_tick),
    .bus_rx      (bus_rx),
    .eof_ind     (eof_ind),
    .err_passive (err_passive),
    .cnt         (bit_cnt),
    .phase       (phase),
    .cnt_clr     (cnt_clr),
    .cnt_inc     (cnt_inc),
    .sof_evt     (sof_evt),
    .ovl_evt     (ovl_evt),
    .gap_end_evt (gap_end_evt)
  );

  assign intermission_o = (phase == PH_INTER);
  assign suspend_o      = (phase == PH_SUSP);
  assign idle_o         = (phase == PH_IDLE);
  assign sof_pulse      = sof_evt;
  assign overload_o     = ovl_evt;

  ifs_tx_gate u_gate (
    .tx_req      (tx_req),
    .pend_kind   (pend_kind),
    .in_idle     (idle_o),
    .gap_end_evt (gap_end_evt),
    .tx_permit   (tx_permit)
  );
endmodule

// File: rtl/ifs_gap_ctrl_chk.sv
module ifs_gap_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bit_tick,
  input logic       bus_rx,
  input logic       eof_ind,
  input logic       err_passive,
  input logic [1:0] pend_kind,
  input logic       tx_req,
  input logic       tx_permit,
  input logic       intermission_o,
  input logic       suspend_o,
  input logic       idle_o,
  input logic       sof_pulse,
  input logic       overload_o
);
  p_eof_enters_int_r2: assert property (@(posedge clk) disable iff (!rst_n)
    eof_ind |=> intermission_o);

  p_eof_masks_events_r2: assert property (@(posedge clk) disable iff (!rst_n)
    eof_ind |-> !sof_pulse && !overload_o);

  p_susp_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(suspend_o) |-> $past(err_passive) && $past(intermission_o));

  p_sof_to_frame_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sof_pulse |=> !idle_o && !intermission_o && !suspend_o);

  p_ovl_in_int_r6: assert property (@(posedge clk) disable iff (!rst_n)
    overload_o |-> intermission_o && !sof_pulse && bit_tick && !bus_rx);

  p_permit_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_permit && !pend_kind[1]) |-> tx_req && (idle_o || (bit_tick && bus_rx)));

  p_permit_err_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pend_kind[1] |-> (tx_permit == tx_req));

  p_hold_no_tick_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!bit_tick && !eof_ind) |=> $stable({intermission_o, suspend_o, idle_o}));

  p_flags_onehot_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({intermission_o, suspend_o, idle_o}));
endmodule

bind ifs_gap_ctrl ifs_gap_ctrl_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .bit_tick       (bit_tick),
  .bus_rx         (bus_rx),
  .eof_ind        (eof_ind),
  .err_passive    (err_passive),
  .pend_kind      (pend_kind),
  .tx_req         (tx_req),
  .tx_permit      (tx_permit),
  .intermission_o (intermission_o),
  .suspend_o      (suspend_o),
  .idle_o         (idle_o),
  .sof_pulse      (sof_pulse),
  .overload_o     (overload_o)
);

// File: tb/ifs_gap_ctrl_tb.sv
`timescale 1ns/1ps
module ifs_gap_ctrl_tb;
  localparam int INT_BITS  = 3;
  localparam int SUSP_BITS = 8;

  logic clk = 1'b0;
  logic rst_n, bit_tick, bus_rx, eof_ind, err_passive, tx_req;
  logic [1:0] pend_kind;
  logic tx_permit, intermission_o, suspend_o, idle_o, sof_pulse, overload_o;

  int n_chk = 0;
  int n_fail = 0;
  logic s_permit, s_sof, s_ovl, s_int, s_susp, s_idle;

  always #2.5 clk = ~clk;

  ifs_gap_ctrl #(.INT_BITS(INT_BITS), .SUSP_BITS(SUSP_BITS)) u_dut (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .bus_rx(bus_rx),
    .eof_ind(eof_ind), .err_passive(err_passive), .pend_kind(pend_kind),
    .tx_req(tx_req), .tx_permit(tx_permit), .intermission_o(intermission_o),
    .suspend_o(suspend_o), .idle_o(idle_o), .sof_pulse(sof_pulse),
    .overload_o(overload_o)
  );

  task automatic chk(input logic act, input logic exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // Drive one clock: inputs at negedge, event outputs before the edge, flags after it.
  task automatic cyc(input logic tk, input logic bus, input logic eof);
    @(negedge clk);
    bit_tick = tk; bus_rx = bus; eof_ind = eof;
    #1;
    s_permit = tx_permit; s_sof = sof_pulse; s_ovl = overload_o;
    @(posedge clk);
    #1;
    s_int = intermission_o; s_susp = suspend_o; s_idle = idle_o;
  endtask

  task automatic chk_flags(input logic ei, input logic es, input logic ed, input string req);
    chk(s_int, ei, {req, " intermission"});
    chk(s_susp, es, {req, " suspend"});
    chk(s_idle, ed, {req, " idle"});
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bit_tick = 1'b0; bus_rx = 1'b1; eof_ind = 1'b0;
    err_passive = 1'b0; tx_req = 1'b0; pend_kind = 2'd0;
    repeat (3) cyc(0, 1, 0);
    // R1 reset state
    chk_flags(0, 0, 1, "R1");
    chk(s_sof, 0, "R1 sof");
    chk(s_ovl, 0, "R1 overload");
    @(negedge clk); rst_n = 1'b1;

    // Sweep: dominant bit at each position after end of frame, both error states.
    for (int ep = 0; ep < 2; ep++) begin
      automatic int gaplen = INT_BITS + (ep != 0 ? SUSP_BITS : 0);
      err_passive = (ep != 0);
      for (int d = 0; d <= gaplen + 1; d++) begin
        tx_req = 1'b1; pend_kind = 2'd0;
        cyc(0, 1, 1);
        chk_flags(1, 0, 0, "R2 eof");
        for (int i = 0; i <= d; i++) begin
          automatic logic bus = (i != d);
          automatic int n = i + 1;
          automatic logic e_perm = (i >= gaplen) || ((i == gaplen - 1) && bus);
          if (i == 1) begin
            cyc(0, 0, 0); // R10 dominant level without tick
            chk_flags((i < INT_BITS), (ep != 0) && (i >= INT_BITS) && (i < gaplen),
                      (i >= gaplen), "R10 no tick");
          end
          cyc(1, bus, 0);
          chk(s_permit, e_perm, "R8 permit");
          chk(s_ovl, !bus && (i < INT_BITS - 1), "R6 overload");
          chk(s_sof, !bus && (i >= INT_BITS - 1), (i == INT_BITS - 1) ? "R7 sof" : "R5 sof");
          if (bus)
            chk_flags((n < INT_BITS), (ep != 0) && (n >= INT_BITS) && (n < gaplen),
                      (n >= gaplen), (ep != 0) ? "R4 gap" : "R3 gap");
          else
            chk_flags(0, 0, 0, "R5 frame");
        end
        if (d <= gaplen - 1) begin
          // now in frame state: bus activity ignored
          cyc(1, 1, 0);
          chk_flags(0, 0, 0, "R11 frame");
          cyc(1, 0, 0);
          chk(s_sof, 0, "R11 sof");
          chk_flags(0, 0, 0, "R11 frame");
          chk(s_permit, 0, "R8 frame permit");
          pend_kind = 2'd2;
          cyc(0, 1, 0);
          chk(s_permit, 1, "R9 error permit");
          pend_kind = 2'd3; tx_req = 1'b0;
          cyc(0, 1, 0);
          chk(s_permit, 0, "R9 overload no req");
        end
      end
    end

    // R2: restart of the gap in the middle of suspend
    err_passive = 1'b1; pend_kind = 2'd1; tx_req = 1'b1;
    cyc(0, 1, 1);
    for (int i = 0; i < INT_BITS + 4; i++) cyc(1, 1, 0);
    chk_flags(0, 1, 0, "R4 mid suspend");
    cyc(1, 0, 1);
    chk(s_sof, 0, "R2 eof beats sof");
    chk_flags(1, 0, 0, "R2 restart");
    err_passive = 1'b0;
    for (int i = 0; i < INT_BITS; i++) begin
      cyc(1, 1, 0);
      chk(s_permit, (i == INT_BITS - 1), "R8 remote permit");
    end
    chk_flags(0, 0, 1, "R2 count cleared");
    cyc(0, 0, 0);
    chk(s_permit, 1, "R8 idle permit");
    tx_req = 1'b0;
    cyc(0, 1, 0);
    chk(s_permit, 0, "R8 no request");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule